// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the operand-steering and interlock brain of a five-stage in-order pipeline that carries both integer and floating-point instructions. Each cycle it looks at the source registers of the instruction in decode and the instruction in execute. It compares them against the destinations of the older instructions in execute, memory and writeback, and against the destinations of floating-point operations still running inside multi-cycle units. From these comparisons it produces mux selects for the execute-stage operands, mux selects for the decode-stage operands, and one stall that freezes the PC and the fetch/decode register while it turns the decode/execute control into a bubble. It also produces a flush of the fetch/decode register for a taken branch.

Register identifiers are 6-bit tags. Bit 5 names the file (0 integer, 1 floating point) and bits 4:0 the index. Because comparisons use the full tag, a producer in one path feeds a consumer in the other path with no special case, for example a move between files. Branches are compared and targeted in decode, so decode operands need their own bypass and interlock. The register file writes before it reads, so nothing is bypassed from writeback into decode. The block also holds one sticky exception flag that the datapath sets and that only reset clears.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An execute operand whose used source tag equals the memory-stage destination, with that producer writing and not a load, gets select 1 (encoding: 0 register file, 1 memory-stage result, 2 writeback-stage result).
- R2: An execute operand gets select 2 when it matches a writing writeback-stage producer and the memory stage does not supply it. When both stages match, select 1 wins, because the younger producer is preferred.
- R3: Tag 6'h00 (integer register 0) never forwards and never stalls. Tag 6'h20 (FP register 0) behaves like any other register. A tag differing only in bit 5 does not match, and an equal tag matches whatever the producer's unit.
- R4: A load in the memory stage is never an execute-operand source at select 1. An older writeback match may still give select 2.
- R5: A used decode source that matches a writing load in execute raises stall_pc, stall_ifid and bubble_idex together.
- R6: A branch in decode with a used source that matches any writing instruction in execute stalls. A non-branch with the same dependence on a non-load does not stall.
- R7: A branch in decode with a used source that matches a writing load in the memory stage stalls.
- R8: A decode operand select is 1 when its used source matches a writing non-load memory-stage producer, with no stall. A match only in writeback gives neither select nor stall.
- R9: A used decode source that matches any valid pending FP destination stalls. A matching slot whose valid bit is 0 has no effect.
- R10: flush_ifid equals br_taken when no stall is raised, and is 0 while stalling.
- R11: exc_flag is 0 after reset, becomes 1 on the clock edge that samples exc_in high, and holds until rst_n is low at an edge.
- R12: A source whose use bit is 0 causes no forward select and no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the exception flag |
| rst_n | input | 1 | Synchronous active-low reset |
| id_src_a | input | 6 | Decode source A tag |
| id_src_b | input | 6 | Decode source B tag |
| id_use_a | input | 1 | Decode reads source A |
| id_use_b | input | 1 | Decode reads source B |
| id_branch | input | 1 | Decode instruction is a branch (reads operands in decode) |
| br_taken | input | 1 | Decode branch resolved taken |
| ex_src_a | input | 6 | Execute source A tag |
| ex_src_b | input | 6 | Execute source B tag |
| ex_use_a | input | 1 | Execute reads source A |
| ex_use_b | input | 1 | Execute reads source B |
| ex_dst | input | 6 | Execute destination tag |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 6 | Memory-stage destination tag |
| mem_wen | input | 1 | Memory-stage instruction writes |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 6 | Writeback destination tag |
| wb_wen | input | 1 | Writeback instruction writes |
| fp_pend_vld | input | 4 | Valid bit per pending FP slot |
| fp_pend_dst | input | 24 | Pending FP destination tags, slot n at bits 6n+5:6n |
| exc_in | input | 1 | Exception raised this cycle |
| fwd_ex_a | output | 2 | Execute operand A select |
| fwd_ex_b | output | 2 | Execute operand B select |
| fwd_id_a | output | 1 | Decode operand A takes memory-stage result |
| fwd_id_b | output | 1 | Decode operand B takes memory-stage result |
| stall_pc | output | 1 | Hold the PC |
| stall_ifid | output | 1 | Hold the fetch/decode register |
| bubble_idex | output | 1 | Zero decode/execute control |
| flush_ifid | output | 1 | Clear the fetch/decode register |
| exc_flag | output | 1 | Sticky exception flag |

## Verification
The properties take for granted that the stage descriptors describe a legal pipeline. A load sitting in the memory stage is never paired with an execute-stage consumer of its result, since the interlock would have held that consumer back. They also assume that use and write-enable bits are clean levels. The stimulus applies one complete descriptor set per cycle and builds each case from single dependences plus chosen overlaps, such as both producers matching or a taken branch under a stall. It never presents an execute consumer of a memory-stage load without an older writeback match that makes the intended select explicit. Reset is applied in the middle of the run only to show the flag clearing.

// File: rtl/phu_pkg.sv
// Shared types for the hazard/forwarding unit.
// Assumes a register tag of one file bit above an index field.
package phu_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;
endpackage

// File: rtl/phu_tag_match.sv
// Single producer/consumer comparison.
// Assumes tag 0 is the hard-wired integer zero register and never a real producer.
module phu_tag_match #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W:0] src,
    input  logic           src_used,
    input  logic [IDX_W:0] dst,
    input  logic           dst_wr,
    output logic           hit
);
    // Equal full tags from a writing producer, excluding integer register zero.
    always_comb hit = src_used && dst_wr && (src == dst) && (dst != '0);
endmodule

// File: rtl/phu_fwd_ex.sv
// Execute-stage operand select for one operand.
// Assumes a memory-stage load never feeds execute directly (interlock prevents it).
module phu_fwd_ex #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W:0] src,
    input  logic           src_used,
    input  logic [IDX_W:0] mem_dst,
    input  logic           mem_wen,
    input  logic           mem_load,
    input  logic [IDX_W:0] wb_dst,
    input  logic           wb_wen,
    output logic [1:0]     sel
);
    import phu_pkg::*;

    logic mem_hit;
    logic wb_hit;

    phu_tag_match #(.IDX_W(IDX_W)) u_mem (
        .src(src), .src_used(src_used), .dst(mem_dst),
        .dst_wr(mem_wen && !mem_load), .hit(mem_hit)
    );

    phu_tag_match #(.IDX_W(IDX_W)) u_wb (
        .src(src), .src_used(src_used), .dst(wb_dst),
        .dst_wr(wb_wen), .hit(wb_hit)
    );

    // Youngest producer first: memory stage beats writeback.
    always_comb begin
        fwd_sel_e s;
        if (mem_hit)     s = FWD_MEM;
        else if (wb_hit) s = FWD_WB;
        else             s = FWD_RF;
        sel = s;
    end
endmodule

// File: rtl/phu_stall_ctl.sv
// Decode-stage interlock, decode bypass select and fetch/decode flush.
// Assumes branch compare reads operands in decode, and writeback lands before reads.
module phu_stall_ctl #(
    parameter int IDX_W    = 5,
    parameter int NUM_PEND = 4
) (
    input  logic [IDX_W:0]                id_src_a,
    input  logic [IDX_W:0]                id_src_b,
    input  logic                          id_use_a,
    input  logic                          id_use_b,
    input  logic                          id_branch,
    input  logic                          br_taken,
    input  logic [IDX_W:0]                ex_dst,
    input  logic                          ex_wen,
    input  logic                          ex_load,
    input  logic [IDX_W:0]                mem_dst,
    input  logic                          mem_wen,
    input  logic                          mem_load,
    input  logic [NUM_PEND-1:0]           pend_vld,
    input  logic [NUM_PEND*(IDX_W+1)-1:0] pend_dst,
    output logic                          stall,
    output logic                          fwd_id_a,
    output logic                          fwd_id_b,
    output logic                          flush
);
    localparam int TAG_W = IDX_W + 1;

    logic [1:0][TAG_W-1:0]    src_v;
    logic [1:0]               use_v;
    logic [1:0]               ex_ld_hit;
    logic [1:0]               ex_any_hit;
    logic [1:0]               mem_ld_hit;
    logic [1:0]               mem_alu_hit;
    logic [1:0][NUM_PEND-1:0] pend_bits;
    logic [1:0]               op_stall;

    // Gather both decode operands for the per-operand generate.
    always_comb begin
        src_v[0] = id_src_a;
        src_v[1] = id_src_b;
        use_v[0] = id_use_a;
        use_v[1] = id_use_b;
    end

    for (genvar g = 0; g < 2; g++) begin : g_op
        phu_tag_match #(.IDX_W(IDX_W)) u_ex_ld (
            .src(src_v[g]), .src_used(use_v[g]), .dst(ex_dst),
            .dst_wr(ex_wen && ex_load), .hit(ex_ld_hit[g])
        );
        phu_tag_match #(.IDX_W(IDX_W)) u_ex_any (
            .src(src_v[g]), .src_used(use_v[g]), .dst(ex_dst),
            .dst_wr(ex_wen), .hit(ex_any_hit[g])
        );
        phu_tag_match #(.IDX_W(IDX_W)) u_mem_ld (
            .src(src_v[g]), .src_used(use_v[g]), .dst(mem_dst),
            .dst_wr(mem_wen && mem_load), .hit(mem_ld_hit[g])
        );
        phu_tag_match #(.IDX_W(IDX_W)) u_mem_alu (
            .src(src_v[g]), .src_used(use_v[g]), .dst(mem_dst),
            .dst_wr(mem_wen && !mem_load), .hit(mem_alu_hit[g])
        );
        for (genvar p = 0; p < NUM_PEND; p++) begin : g_pend
            phu_tag_match #(.IDX_W(IDX_W)) u_pend (
                .src(src_v[g]), .src_used(use_v[g]),
                .dst(pend_dst[p*TAG_W +: TAG_W]),
                .dst_wr(pend_vld[p]), .hit(pend_bits[g][p])
            );
        end

        // Per-operand interlock: load-use, branch on execute or memory load, FP in flight.
        always_comb op_stall[g] = ex_ld_hit[g]
                               || (id_branch && ex_any_hit[g])
                               || (id_branch && mem_ld_hit[g])
                               || (|pend_bits[g]);
    end

    // Combine operands into the stall, the decode bypass and the flush.
    always_comb begin
        stall    = |op_stall;
        fwd_id_a = mem_alu_hit[0];
        fwd_id_b = mem_alu_hit[1];
        flush    = br_taken && !stall;
    end
endmodule

// File: rtl/phu_exc_flag.sv
// Sticky exception indicator; the unit only records, never handles.
// Assumes exc_in is a clean level sampled on the rising edge.
module phu_exc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic exc_in,
    output logic flag
);
    // Set on any sampled exception, clear only on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (exc_in) flag <= 1'b1;
    end
endmodule

// File: rtl/pipe_hazard_unit.sv
// Top of the hazard/forwarding control: execute bypass selects, decode
// bypass and interlock, flush, and the exception flag.
// Assumes descriptors of each stage are valid for the whole cycle.
module pipe_hazard_unit #(
    parameter int IDX_W    = 5,
    parameter int NUM_PEND = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W:0]                id_src_a,
    input  logic [IDX_W:0]                id_src_b,
    input  logic                          id_use_a,
    input  logic                          id_use_b,
    input  logic                          id_branch,
    input  logic                          br_taken,
    input  logic [IDX_W:0]                ex_src_a,
    input  logic [IDX_W:0]                ex_src_b,
    input  logic                          ex_use_a,
    input  logic                          ex_use_b,
    input  logic [IDX_W:0]                ex_dst,
    input  logic                          ex_wen,
    input  logic                          ex_load,
    input  logic [IDX_W:0]                mem_dst,
    input  logic                          mem_wen,
    input  logic                          mem_load,
    input  logic [IDX_W:0]                wb_dst,
    input  logic                          wb_wen,
    input  logic [NUM_PEND-1:0]           fp_pend_vld,
    input  logic [NUM_PEND*(IDX_W+1)-1:0] fp_pend_dst,
    input  logic                          exc_in,
    output logic [1:0]                    fwd_ex_a,
    output logic [1:0]                    fwd_ex_b,
    output logic                          fwd_id_a,
    output logic                          fwd_id_b,
    output logic                          stall_pc,
    output logic                          stall_ifid,
    output logic                          bubble_idex,
    output logic                          flush_ifid,
    output logic                          exc_flag
);
    logic stall;

    phu_fwd_ex #(.IDX_W(IDX_W)) u_fwd_a (
        .src(ex_src_a), .src_used(ex_use_a),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .sel(fwd_ex_a)
    );

    phu_fwd_ex #(.IDX_W(IDX_W)) u_fwd_b (
        .src(ex_src_b), .src_used(ex_use_b),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .sel(fwd_ex_b)
    );

    phu_stall_ctl #(.IDX_W(IDX_W), .NUM_PEND(NUM_PEND)) u_stall (
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .id_use_a(id_use_a), .id_use_b(id_use_b),
        .id_branch(id_branch), .br_taken(br_taken),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
        .pend_vld(fp_pend_vld), .pend_dst(fp_pend_dst),
        .stall(stall), .fwd_id_a(fwd_id_a), .fwd_id_b(fwd_id_b),
        .flush(flush_ifid)
    );

    phu_exc_flag u_exc (
        .clk(clk), .rst_n(rst_n), .exc_in(exc_in), .flag(exc_flag)
    );

    // One stall drives all three freeze/bubble controls.
    always_comb begin
        stall_pc    = stall;
        stall_ifid  = stall;
        bubble_idex = stall;
    end
endmodule

// File: rtl/pipe_hazard_unit_chk.sv
// Property checker bound to the hazard unit; observes ports only.
module pipe_hazard_unit_chk #(
    parameter int IDX_W = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic [IDX_W:0] id_src_a,
    input logic           id_use_a,
    input logic [IDX_W:0] ex_src_a,
    input logic           ex_use_a,
    input logic [IDX_W:0] ex_dst,
    input logic           ex_wen,
    input logic           ex_load,
    input logic           mem_wen,
    input logic           mem_load,
    input logic           exc_in,
    input logic [1:0]     fwd_ex_a,
    input logic           stall_pc,
    input logic           flush_ifid,
    input logic           exc_flag
);
    p_mem_src_not_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_ex_a == 2'd1) |-> (mem_wen && !mem_load));

    p_zero_reg_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a == '0) |-> (fwd_ex_a == 2'd0));

    p_unused_no_fwd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_use_a |-> (fwd_ex_a == 2'd0));

    p_load_use_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_use_a && ex_wen && ex_load && (ex_dst == id_src_a) && (ex_dst != '0))
        |-> stall_pc);

    p_no_flush_in_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ifid |-> !stall_pc);

    p_exc_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_in |=> exc_flag);

    p_exc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exc_flag |=> exc_flag);
endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .id_src_a(id_src_a), .id_use_a(id_use_a),
    .ex_src_a(ex_src_a), .ex_use_a(ex_use_a),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_wen(mem_wen), .mem_load(mem_load), .exc_in(exc_in),
    .fwd_ex_a(fwd_ex_a), .stall_pc(stall_pc),
    .flush_ifid(flush_ifid), .exc_flag(exc_flag)
);

// File: tb/pipe_hazard_unit_bench.sv
// Scoreboard bench: driver pushes expected outputs, monitor compares at negedge.
module pipe_hazard_unit_bench;
    localparam int NP = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [5:0]  id_src_a = '0, id_src_b = '0, ex_src_a = '0, ex_src_b = '0;
    logic        id_use_a = 0, id_use_b = 0, id_branch = 0, br_taken = 0;
    logic        ex_use_a = 0, ex_use_b = 0;
    logic [5:0]  ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic        ex_wen = 0, ex_load = 0, mem_wen = 0, mem_load = 0, wb_wen = 0;
    logic [3:0]  fp_pend_vld = '0;
    logic [23:0] fp_pend_dst = '0;
    logic        exc_in = 0;
    logic [1:0]  fwd_ex_a, fwd_ex_b;
    logic        fwd_id_a, fwd_id_b, stall_pc, stall_ifid, bubble_idex, flush_ifid, exc_flag;

    pipe_hazard_unit u_pipe_hazard_unit (.*);

    typedef struct {
        logic [5:0] ida, idb, exa, exb, exd, md, wd;
        logic iua, iub, br, tk, eua, eub, exw, exl, mw, ml, ww, exc, rst_low;
        logic [3:0] pv;
        logic [23:0] pd;
    } vec_t;

    typedef struct {
        string req;
        logic [1:0] fa, fb;
        logic ia, ib, st, fl, ex;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int failures = 0;
    logic model_exc = 1'b0;

    function automatic vec_t idle();
        vec_t v;
        v.ida = 0; v.idb = 0; v.exa = 0; v.exb = 0; v.exd = 0; v.md = 0; v.wd = 0;
        v.iua = 0; v.iub = 0; v.br = 0; v.tk = 0; v.eua = 0; v.eub = 0;
        v.exw = 0; v.exl = 0; v.mw = 0; v.ml = 0; v.ww = 0; v.exc = 0; v.rst_low = 0;
        v.pv = 0; v.pd = 0;
        return v;
    endfunction

    function automatic logic hit(logic [5:0] s, logic u, logic [5:0] d, logic w);
        return u && w && (s == d) && (s != 6'h00);
    endfunction

    function automatic logic [1:0] ex_sel(logic [5:0] s, logic u, vec_t v);
        if (hit(s, u, v.md, v.mw && !v.ml)) return 2'd1;
        if (hit(s, u, v.wd, v.ww)) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic op_stall(logic [5:0] s, logic u, vec_t v);
        logic r;
        r = hit(s, u, v.exd, v.exw && v.exl)
         || (v.br && hit(s, u, v.exd, v.exw))
         || (v.br && hit(s, u, v.md, v.mw && v.ml));
        for (int p = 0; p < NP; p++)
            r = r || hit(s, u, v.pd[p*6 +: 6], v.pv[p]);
        return r;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(vec_t v, string req);
        exp_t e;
        @(posedge clk);
        #1;
        rst_n = !v.rst_low;
        id_src_a = v.ida; id_src_b = v.idb; id_use_a = v.iua; id_use_b = v.iub;
        id_branch = v.br; br_taken = v.tk;
        ex_src_a = v.exa; ex_src_b = v.exb; ex_use_a = v.eua; ex_use_b = v.eub;
        ex_dst = v.exd; ex_wen = v.exw; ex_load = v.exl;
        mem_dst = v.md; mem_wen = v.mw; mem_load = v.ml;
        wb_dst = v.wd; wb_wen = v.ww;
        fp_pend_vld = v.pv; fp_pend_dst = v.pd; exc_in = v.exc;
        e.req = req;
        e.fa = ex_sel(v.exa, v.eua, v);
        e.fb = ex_sel(v.exb, v.eub, v);
        e.ia = hit(v.ida, v.iua, v.md, v.mw && !v.ml);
        e.ib = hit(v.idb, v.iub, v.md, v.mw && !v.ml);
        e.st = op_stall(v.ida, v.iua, v) || op_stall(v.idb, v.iub, v);
        e.fl = v.tk && !e.st;
        e.ex = model_exc;
        model_exc = v.rst_low ? 1'b0 : (model_exc | v.exc);
        sbq.push_back(e);
    endtask

    // Monitor: pop one expectation per cycle, compare away from the rising edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.req, "fwd_ex_a", fwd_ex_a, e.fa);
            chk(e.req, "fwd_ex_b", fwd_ex_b, e.fb);
            chk(e.req, "fwd_id_a", fwd_id_a, e.ia);
            chk(e.req, "fwd_id_b", fwd_id_b, e.ib);
            chk(e.req, "stall_pc", stall_pc, e.st);
            chk(e.req, "stall_ifid", stall_ifid, e.st);
            chk(e.req, "bubble_idex", bubble_idex, e.st);
            chk(e.req, "flush_ifid", flush_ifid, e.fl);
            chk(e.req, "exc_flag", exc_flag, e.ex);
        end
    end

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "exc_flag in reset", exc_flag, 0);

        v = idle(); drive(v, "R12");
        // R1: execute A from memory stage, integer r3
        v = idle(); v.exa = 6'h03; v.eua = 1; v.md = 6'h03; v.mw = 1; drive(v, "R1");
        // R2: execute B from writeback
        v = idle(); v.exb = 6'h07; v.eub = 1; v.wd = 6'h07; v.ww = 1; drive(v, "R2");
        // R2: both stages match, memory stage wins
        v = idle(); v.exa = 6'h09; v.eua = 1; v.md = 6'h09; v.mw = 1; v.wd = 6'h09; v.ww = 1; drive(v, "R2");
        // R4: load in memory stage skipped, writeback used
        v = idle(); v.exa = 6'h0A; v.eua = 1; v.md = 6'h0A; v.mw = 1; v.ml = 1; v.wd = 6'h0A; v.ww = 1; drive(v, "R4");
        // R3: integer r0 never forwarded or stalled
        v = idle(); v.exa = 6'h00; v.eua = 1; v.md = 6'h00; v.mw = 1;
        v.ida = 6'h00; v.iua = 1; v.exd = 6'h00; v.exw = 1; v.exl = 1; drive(v, "R3");
        // R3: FP r0 forwards; cross-file same index does not match
        v = idle(); v.exa = 6'h20; v.eua = 1; v.md = 6'h20; v.mw = 1;
        v.exb = 6'h05; v.eub = 1; v.wd = 6'h25; v.ww = 1; drive(v, "R3");
        // R5 and R10: load-use stall suppresses a taken-branch flush
        v = idle(); v.ida = 6'h04; v.iua = 1; v.exd = 6'h04; v.exw = 1; v.exl = 1; v.tk = 1; drive(v, "R5");
        // R12: same dependence with source unused
        v = idle(); v.ida = 6'h04; v.exd = 6'h04; v.exw = 1; v.exl = 1; drive(v, "R12");
        // R6: branch on execute ALU result stalls
        v = idle(); v.idb = 6'h11; v.iub = 1; v.br = 1; v.exd = 6'h11; v.exw = 1; drive(v, "R6");
        // R6: non-branch with same ALU dependence does not stall
        v = idle(); v.idb = 6'h11; v.iub = 1; v.exd = 6'h11; v.exw = 1; drive(v, "R6");
        // R7: branch on load in memory stage stalls
        v = idle(); v.ida = 6'h12; v.iua = 1; v.br = 1; v.md = 6'h12; v.mw = 1; v.ml = 1; drive(v, "R7");
        // R8 and R10: branch on ALU result in memory stage bypasses, taken branch flushes
        v = idle(); v.ida = 6'h13; v.iua = 1; v.br = 1; v.tk = 1; v.md = 6'h13; v.mw = 1; drive(v, "R8");
        // R8: writeback-only match gives no decode bypass and no stall
        v = idle(); v.idb = 6'h14; v.iub = 1; v.br = 1; v.wd = 6'h14; v.ww = 1; drive(v, "R8");
        // R9: pending FP slot 3 matches
        v = idle(); v.ida = 6'h2C; v.iua = 1; v.pv = 4'b1000; v.pd[23:18] = 6'h2C; drive(v, "R9");
        // R9: matching slot not valid
        v = idle(); v.ida = 6'h2C; v.iua = 1; v.pv = 4'b0111; v.pd[23:18] = 6'h2C; drive(v, "R9");
        // R10: taken branch without hazards flushes
        v = idle(); v.br = 1; v.tk = 1; drive(v, "R10");
        // R11: raise, hold, reset, cleared
        v = idle(); v.exc = 1; drive(v, "R11");
        v = idle(); drive(v, "R11");
        v = idle(); v.rst_low = 1; drive(v, "R11");
        v = idle(); drive(v, "R11");
        v = idle(); drive(v, "R11");

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule